// File: doc/BRIEF.md
# Twelve-Channel Memory/Peripheral Transfer Engine

This block moves data between memory and peripheral data registers on behalf of software. It has twelve channels, and each channel is set up through a 32-bit register port. Software gives each channel a memory window as a pair of start and end byte addresses, a device address, a transfer direction and a unit size. When software sets the run bit, the channel moves one unit each time its selected peripheral request line is high and the engine grants it the bus. Every unit is a read from the source followed by a write to the destination, and both go through one memory-side master port.

Progress is kept in the memory start register. It advances by the unit size after each unit. When it reaches the end register the channel raises its done flag. The done flag is sticky and software clears it by writing a 1 to it. Each channel can turn its done flag into an interrupt. Any of the twelve request lines can pace any channel. When several channels are ready at once, the lowest-numbered ready channel wins, and only one unit is ever in flight on the master port.

The master port uses valid/ready. Once the engine raises `m_valid`, it holds `m_valid`, `m_write`, `m_addr`, `m_wdata` and `m_bytes` unchanged until a cycle in which `m_ready` is high, which is the cycle the beat is taken. A low `m_ready` stalls the engine for as long as it stays low. Data is moved as a whole 32-bit word without lane shifting, and `m_bytes` tells the responder how many bytes are meaningful.

Top module: `xdma_top`

## Requirements
- R1: After reset every register reads 0, `m_valid` is 0 and all `irq` bits are 0.
- R2: Register map, byte addressed. 0x00 is the global control word, and its bit 0 enables the engine. 0x04 is a read/write scratch word. 0x08 and 0x0C read 0. Channel n occupies 0x10+32n, with words in this order: +0x00 activate (bit 0 enables the channel), +0x04 memory start, +0x08 memory end, +0x0C device address, +0x10 control, +0x14 status, +0x18 interrupt enable, +0x1C reserved (reads 0). The writable words read back as written.
- R3: Control word: bit 0 is run. Bit 8 set means memory-to-device and clear means device-to-memory. Bits 12:9 select the request line. Bit 16 set means the memory address follows the start register, and clear means it stays at the start value captured when run was set. Bit 17 set means the device address steps by the unit size. Bits 22:20 give the unit size in bytes.
- R4: A channel is eligible only when the global enable, its activate bit 0 and its run bit are all set, its selected request line is high, its size is 1, 2 or 4, and start differs from end. A select value of 12 or more never requests.
- R5: One unit is a read of the source address, then a write of the data read to the destination address. The source is memory for memory-to-device and the device address otherwise.
- R6: `m_valid` with a stable address, direction and data is held until `m_ready`. Only one beat is outstanding, and read data is taken in the cycle `m_ready` is high.
- R7: After each unit's write is accepted, start grows by the unit size, and the device address grows by it as well when bit 17 is set.
- R8: Done (status bit 2) is set when a unit brings start up to end. Setting run while start equals end sets done at that write, with no bus activity.
- R9: Writing status with bit 2 set clears done. Writing it with bit 2 clear leaves done unchanged.
- R10: `irq[n]` is channel n's done flag ANDed with bit 2 of its interrupt enable word.
- R11: When the master is idle and several channels are eligible, the lowest-numbered one is served first.
- R12: After run is cleared, the channel starts no further unit, even while its request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dreq | input | 12 | Peripheral request lines |
| irq | output | 12 | Per-channel interrupt |
| m_valid | output | 1 | Master beat valid |
| m_write | output | 1 | Beat is a write (1) or a read (0) |
| m_addr | output | 32 | Beat byte address |
| m_wdata | output | 32 | Write data |
| m_bytes | output | 3 | Meaningful bytes in the beat |
| m_ready | input | 1 | Responder accepts the beat |
| m_rdata | input | 32 | Read data, valid with m_ready on a read |

## Verification
A register write takes effect at the clock edge that samples it, and a read returns the value in the same cycle. If a channel is eligible while the master is idle in cycle t, its read beat appears in cycle t+1. The write beat follows the cycle after the read is accepted. Start, device address and done change at the edge that accepts the write. The bench drives inputs and samples outputs at falling edges. It checks registers only after polling done, or after a fixed wait that is far longer than one unit. It also checks the bus-hold rule on every cycle against the previous cycle's beat, while the ready line stalls at random.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_e;

  // word indices inside a channel block
  localparam logic [2:0] WI_ACT   = 3'd0;
  localparam logic [2:0] WI_START = 3'd1;
  localparam logic [2:0] WI_END   = 3'd2;
  localparam logic [2:0] WI_DEV   = 3'd3;
  localparam logic [2:0] WI_CTRL  = 3'd4;
  localparam logic [2:0] WI_STAT  = 3'd5;
  localparam logic [2:0] WI_IEN   = 3'd6;

  // control bit positions
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_TODEV  = 8;
  localparam int unsigned CB_SEL_LO = 9;
  localparam int unsigned CB_INCMEM = 16;
  localparam int unsigned CB_INCDEV = 17;
  localparam int unsigned CB_SZ_LO  = 20;
  localparam int unsigned SB_DONE   = 2;

  function automatic logic unit_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/xdma_chan.sv
module xdma_chan
  import xdma_pkg::*;
#(
  parameter int N_REQ = 12,
  parameter int SEL_W = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_en,
  input  logic             wr_en,
  input  logic [2:0]       wr_idx,
  input  logic [DW-1:0]    wdata,
  input  logic [2:0]       rd_idx,
  output logic [DW-1:0]    rdata,
  input  logic [N_REQ-1:0] dreq,
  input  logic             step,
  output logic             eligible,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr,
  output logic [2:0]       unit_bytes,
  output logic             irq
);
  localparam int REQ_EXT = 2 ** SEL_W;

  logic [DW-1:0] act_q, ctrl_q, ien_q;
  logic [AW-1:0] start_q, end_q, dev_q, base_q;
  logic          done_q;

  logic             run, to_dev, inc_mem, inc_dev, req_hit;
  logic [SEL_W-1:0] sel;
  logic [2:0]       sz;
  logic [REQ_EXT-1:0] req_ext;
  logic [AW-1:0]    mem_addr, step_start;
  logic             wr_start, wr_dev, wr_ctrl, clr_done, set_done;

  assign run     = ctrl_q[CB_RUN];
  assign to_dev  = ctrl_q[CB_TODEV];
  assign inc_mem = ctrl_q[CB_INCMEM];
  assign inc_dev = ctrl_q[CB_INCDEV];
  assign sel     = ctrl_q[CB_SEL_LO +: SEL_W];
  assign sz      = ctrl_q[CB_SZ_LO +: 3];

  always_comb begin
    req_ext = '0;
    req_ext[N_REQ-1:0] = dreq;
  end
  assign req_hit = req_ext[sel];

  assign mem_addr   = inc_mem ? start_q : base_q;
  assign src_addr   = to_dev ? mem_addr : dev_q;
  assign dst_addr   = to_dev ? dev_q : mem_addr;
  assign unit_bytes = sz;
  assign step_start = start_q + AW'(sz);

  assign eligible = glob_en && act_q[0] && run && unit_ok(sz) && req_hit
                    && (start_q != end_q);

  assign wr_start = wr_en && (wr_idx == WI_START);
  assign wr_dev   = wr_en && (wr_idx == WI_DEV);
  assign wr_ctrl  = wr_en && (wr_idx == WI_CTRL);
  assign clr_done = wr_en && (wr_idx == WI_STAT) && wdata[SB_DONE];
  assign set_done = (step && (step_start == end_q))
                 || (wr_ctrl && wdata[CB_RUN] && !run && (start_q == end_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= '0;
      ctrl_q  <= '0;
      ien_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      dev_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      if (step) begin
        start_q <= step_start;
        if (inc_dev) dev_q <= dev_q + AW'(sz);
      end
      if (wr_start && !step) start_q <= wdata;
      if (wr_dev && !step)   dev_q   <= wdata;
      if (wr_en && wr_idx == WI_ACT) act_q <= wdata;
      if (wr_en && wr_idx == WI_END) end_q <= wdata;
      if (wr_en && wr_idx == WI_IEN) ien_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q <= wdata;
        if (wdata[CB_RUN] && !run) base_q <= start_q;
      end
      done_q <= set_done || (done_q && !clr_done);
    end
  end

  always_comb begin
    case (rd_idx)
      WI_ACT:   rdata = act_q;
      WI_START: rdata = start_q;
      WI_END:   rdata = end_q;
      WI_DEV:   rdata = dev_q;
      WI_CTRL:  rdata = ctrl_q;
      WI_STAT:  rdata = DW'({done_q, 2'b00});
      WI_IEN:   rdata = ien_q;
      default:  rdata = '0;
    endcase
  end

  assign irq = done_q && ien_q[SB_DONE];

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_done |=> done_q);  // R9
  AST_START_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !wr_start |=> $stable(start_q));  // R7

endmodule

// File: rtl/xdma_arb.sv
module xdma_arb #(
  parameter int NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] gnt,
  output logic           gnt_any
);
  always_comb begin
    gnt = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) gnt = NCH'(1) << i;
    end
  end
  assign gnt_any = |elig;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));  // R11
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    elig[0] |-> gnt[0]);  // R11

endmodule

// File: rtl/xdma_mover.sv
module xdma_mover
  import xdma_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int IDX_W = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [2:0]       bytes_i,
  output logic             idle_o,
  output logic [NCH-1:0]   step_o,
  output logic             m_valid,
  output logic             m_write,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  output logic [2:0]       m_bytes,
  input  logic             m_ready,
  input  logic [DW-1:0]    m_rdata
);
  mv_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [2:0]       bytes_q;
  logic [DW-1:0]    data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      idx_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      bytes_q <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (start_i) begin
          idx_q   <= idx_i;
          src_q   <= src_i;
          dst_q   <= dst_i;
          bytes_q <= bytes_i;
          state_q <= MV_READ;
        end
        MV_READ: if (m_ready) begin
          data_q  <= m_rdata;
          state_q <= MV_WRITE;
        end
        MV_WRITE: if (m_ready) state_q <= MV_IDLE;
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == MV_IDLE);
  assign m_valid = (state_q != MV_IDLE);
  assign m_write = (state_q == MV_WRITE);
  assign m_addr  = (state_q == MV_WRITE) ? dst_q : src_q;
  assign m_wdata = data_q;
  assign m_bytes = bytes_q;

  for (genvar g = 0; g < NCH; g++) begin : g_step
    assign step_o[g] = (state_q == MV_WRITE) && m_ready && (idx_q == IDX_W'(g));
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write)
                            && $stable(m_wdata) && $stable(m_bytes));  // R6

endmodule

// File: rtl/xdma_top.sv
module xdma_top
  import xdma_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int SEL_W = 4,
  parameter int RA_W  = 10,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NCH-1:0]  dreq,
  output logic [NCH-1:0]  irq,
  output logic            m_valid,
  output logic            m_write,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  output logic [2:0]      m_bytes,
  input  logic            m_ready,
  input  logic [DW-1:0]   m_rdata
);
  localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int HDR_B   = 16;
  localparam int CIDX_W  = RA_W - 5;

  logic [DW-1:0] glob_ctl_q, glob_data_q;

  logic [RA_W-1:0]   off;
  logic              is_glob, ch_hit;
  logic [CIDX_W-1:0] ch_idx;
  logic [2:0]        word;

  logic [DW-1:0]  ch_rdata [NCH];
  logic [AW-1:0]  ch_src   [NCH];
  logic [AW-1:0]  ch_dst   [NCH];
  logic [2:0]     ch_bytes [NCH];
  logic [NCH-1:0] elig, gnt, step;
  logic           gnt_any, mv_idle, mv_start;
  logic [IDX_W-1:0] gnt_idx;
  logic [AW-1:0]  sel_src, sel_dst;
  logic [2:0]     sel_bytes;

  assign off     = reg_addr - RA_W'(HDR_B);
  assign is_glob = (reg_addr < RA_W'(HDR_B));
  assign ch_idx  = off[RA_W-1:5];
  assign ch_hit  = !is_glob && (ch_idx < CIDX_W'(NCH));
  assign word    = off[4:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_ctl_q  <= '0;
      glob_data_q <= '0;
    end else if (reg_we && is_glob) begin
      if (reg_addr[3:2] == 2'd0) glob_ctl_q  <= reg_wdata;
      if (reg_addr[3:2] == 2'd1) glob_data_q <= reg_wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    xdma_chan #(.N_REQ(NCH), .SEL_W(SEL_W), .AW(AW), .DW(DW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .glob_en    (glob_ctl_q[0]),
      .wr_en      (reg_we && ch_hit && (ch_idx == CIDX_W'(g))),
      .wr_idx     (word),
      .wdata      (reg_wdata),
      .rd_idx     (word),
      .rdata      (ch_rdata[g]),
      .dreq       (dreq),
      .step       (step[g]),
      .eligible   (elig[g]),
      .src_addr   (ch_src[g]),
      .dst_addr   (ch_dst[g]),
      .unit_bytes (ch_bytes[g]),
      .irq        (irq[g])
    );
  end

  xdma_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .gnt     (gnt),
    .gnt_any (gnt_any)
  );

  always_comb begin
    gnt_idx   = '0;
    sel_src   = '0;
    sel_dst   = '0;
    sel_bytes = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        gnt_idx   = IDX_W'(i);
        sel_src   = ch_src[i];
        sel_dst   = ch_dst[i];
        sel_bytes = ch_bytes[i];
      end
    end
  end

  assign mv_start = gnt_any && mv_idle;

  xdma_mover #(.NCH(NCH), .IDX_W(IDX_W), .AW(AW), .DW(DW)) u_mover (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (mv_start),
    .idx_i   (gnt_idx),
    .src_i   (sel_src),
    .dst_i   (sel_dst),
    .bytes_i (sel_bytes),
    .idle_o  (mv_idle),
    .step_o  (step),
    .m_valid (m_valid),
    .m_write (m_write),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_bytes (m_bytes),
    .m_ready (m_ready),
    .m_rdata (m_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    if (is_glob) begin
      case (reg_addr[3:2])
        2'd0:    reg_rdata = glob_ctl_q;
        2'd1:    reg_rdata = glob_data_q;
        default: reg_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit && ch_idx == CIDX_W'(i)) reg_rdata = ch_rdata[i];
      end
    end
  end

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> glob_ctl_q[0]);  // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step));  // R6

endmodule

// File: tb/xdma_top_bench.sv
module xdma_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] dreq = '0;
  logic [11:0] irq;
  logic        m_valid, m_write;
  logic [31:0] m_addr, m_wdata;
  logic [2:0]  m_bytes;
  logic        m_ready = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  xdma_top u_xdma_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .irq(irq),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_bytes(m_bytes), .m_ready(m_ready), .m_rdata(m_rdata)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  int vcount = 0;
  int hold_err = 0;
  int rlog_n = 0;
  logic [31:0] rlog [8];
  logic lv = 1'b0, lr = 1'b0, lw = 1'b0;
  logic [31:0] la = '0, ld = '0;

  // responder: all activity at the falling edge
  always @(negedge clk) begin
    if (lv && !lr && !(m_valid && m_addr == la && m_write == lw && m_wdata == ld))
      hold_err++;
    if (lv && lr) begin
      if (lw) mem[la[9:2]] = ld;
      else if (rlog_n < 8) begin rlog[rlog_n] = la; rlog_n++; end
    end
    if (m_valid) vcount++;
    m_ready = m_valid && (($urandom % 4) != 0);
    m_rdata = mem[m_addr[9:2]];
    lv = m_valid; lr = m_ready; lw = m_write; la = m_addr; ld = m_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] cha(input int ch, input int w);
    return 10'(16 + 32 * ch + 4 * w);
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit run, input bit todev, input int sel,
                                          input bit incm, input bit incd, input int sz);
    return 32'(run) | (32'(todev) << 8) | (32'(sel) << 9) | (32'(incm) << 16)
         | (32'(incd) << 17) | (32'(sz) << 20);
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input int ch);
    logic [31:0] s;
    for (int k = 0; k < 600; k++) begin
      rd(cha(ch, 5), s);
      if (s[2]) break;
    end
  endtask

  task automatic model(input logic [31:0] st, input logic [31:0] en, inout logic [31:0] dv,
                       input bit todev, input bit incm, input bit incd, input int sz);
    logic [31:0] cur, ma, s, d;
    cur = st;
    while (cur != en) begin
      ma = incm ? cur : st;
      s = todev ? ma : dv;
      d = todev ? dv : ma;
      shadow[d[9:2]] = shadow[s[9:2]];
      cur += 32'(sz);
      if (incd) dv += 32'(sz);
    end
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int k = 0; k < 256; k++) if (mem[k] !== shadow[k]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic prog(input int ch, input logic [31:0] st, input logic [31:0] en,
                      input logic [31:0] dv, input logic [31:0] ctl);
    wr(cha(ch, 4), 32'd0);
    wr(cha(ch, 0), 32'd1);
    wr(cha(ch, 1), st);
    wr(cha(ch, 2), en);
    wr(cha(ch, 3), dv);
    wr(cha(ch, 5), 32'd4);
    wr(cha(ch, 4), ctl);
  endtask

  task automatic run_all();
    logic [31:0] v, dv;
    int vb;
    for (int k = 0; k < 256; k++) begin
      mem[k] = 32'hA500_0000 ^ (32'(k) * 32'h0101_0101);
      shadow[k] = mem[k];
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(10'h000, v); chk("R1 global ctl", v, 0);
    rd(cha(0, 4), v); chk("R1 ch0 ctrl", v, 0);
    rd(cha(11, 1), v); chk("R1 ch11 start", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 m_valid", 32'(m_valid), 0);
    // R2 register map
    wr(10'h004, 32'hDEAD_BEEF); rd(10'h004, v); chk("R2 scratch", v, 32'hDEAD_BEEF);
    wr(10'h008, 32'h1234_5678); rd(10'h008, v); chk("R2 reserved hdr", v, 0);
    wr(cha(11, 2), 32'h0000_0ABC); rd(cha(11, 2), v); chk("R2 ch11 end", v, 32'h0000_0ABC);
    wr(cha(11, 7), 32'hFFFF_FFFF); rd(cha(11, 7), v); chk("R2 ch reserved", v, 0);
    // R4 global enable off blocks movement
    dreq[2] = 1'b1;
    prog(2, 32'h40, 32'h50, 32'h300, mk_ctrl(1, 1, 2, 1, 0, 4));
    repeat (20) @(negedge clk);
    rd(cha(2, 1), v); chk("R4 global off start", v, 32'h40);
    chk("R4 global off bus", 32'(vcount), 0);
    wr(10'h000, 32'd1);
    wait_done(2);
    dreq[2] = 1'b0;
    dv = 32'h300; model(32'h40, 32'h50, dv, 1, 1, 0, 4);
    mem_cmp("R5 mem to dev contents");
    rd(cha(2, 1), v); chk("R7 start reached end", v, 32'h50);
    rd(cha(2, 5), v); chk("R8 done set", v, 32'd4);
    // R10 interrupt gating
    chk("R10 irq off w/o enable", 32'(irq[2]), 0);
    wr(cha(2, 6), 32'd4); chk("R10 irq on", 32'(irq[2]), 1);
    // R9 write-one-to-clear
    wr(cha(2, 5), 32'd0); rd(cha(2, 5), v); chk("R9 write 0 keeps done", v, 32'd4);
    wr(cha(2, 5), 32'd4); rd(cha(2, 5), v); chk("R9 write 1 clears done", v, 0);
    chk("R10 irq follows done", 32'(irq[2]), 0);
    // R8 zero-length window
    vb = vcount;
    dreq[7] = 1'b1;
    prog(7, 32'h80, 32'h80, 32'h380, mk_ctrl(1, 0, 7, 1, 0, 2));
    rd(cha(7, 5), v); chk("R8 zero length done", v, 32'd4);
    repeat (10) @(negedge clk);
    chk("R8 zero length no bus", 32'(vcount), 32'(vb));
    dreq[7] = 1'b0;
    // R4 select out of range
    vb = vcount;
    dreq = 12'hFFF;
    prog(0, 32'h100, 32'h104, 32'h200, mk_ctrl(1, 0, 13, 1, 0, 4));
    repeat (20) @(negedge clk);
    rd(cha(0, 1), v); chk("R4 select 13 start", v, 32'h100);
    chk("R4 select 13 bus", 32'(vcount), 32'(vb));
    dreq = '0;
    // R12 run cleared
    vb = vcount;
    prog(1, 32'h20, 32'h30, 32'h320, mk_ctrl(1, 1, 1, 1, 0, 4));
    wr(cha(1, 4), mk_ctrl(0, 1, 1, 1, 0, 4));
    dreq[1] = 1'b1;
    repeat (20) @(negedge clk);
    rd(cha(1, 1), v); chk("R12 start frozen", v, 32'h20);
    chk("R12 no bus", 32'(vcount), 32'(vb));
    dreq[1] = 1'b0;
    // R11 priority: ch3 beats ch5
    wr(10'h000, 32'd0);
    dreq[3] = 1'b1; dreq[5] = 1'b1;
    prog(5, 32'h00, 32'h04, 32'h300, mk_ctrl(1, 1, 5, 1, 0, 4));
    prog(3, 32'h60, 32'h64, 32'h310, mk_ctrl(1, 1, 3, 1, 0, 4));
    rlog_n = 0;
    wr(10'h000, 32'd1);
    wait_done(5); wait_done(3);
    dreq = '0;
    chk("R11 first read is ch3", rlog[0], 32'h60);
    chk("R11 second read is ch5", rlog[1], 32'h00);
    dv = 32'h310; model(32'h60, 32'h64, dv, 1, 1, 0, 4);
    dv = 32'h300; model(32'h00, 32'h04, dv, 1, 1, 0, 4);
    mem_cmp("R11 contents");
    // random channel programs (R3 R5 R7 R8)
    for (int it = 0; it < 14; it++) begin
      int ch, sel, sz, n;
      bit todev, incm, incd;
      logic [31:0] st, en, d0, dexp;
      ch = $urandom % 12; sel = $urandom % 12;
      case ($urandom % 3) 0: sz = 1; 1: sz = 2; default: sz = 4; endcase
      n = 1 + ($urandom % 5);
      todev = 1'($urandom); incm = 1'($urandom); incd = 1'($urandom);
      st = 32'(($urandom % 32) * 4);
      en = st + 32'(n * sz);
      d0 = 32'h200 + 32'(($urandom % 64) * 4);
      dreq[sel] = 1'b1;
      prog(ch, st, en, d0, mk_ctrl(1, todev, sel, incm, incd, sz));
      wait_done(ch);
      dreq = '0;
      dexp = d0; model(st, en, dexp, todev, incm, incd, sz);
      mem_cmp("R5 R3 random contents");
      rd(cha(ch, 1), v); chk("R7 random start", v, en);
      rd(cha(ch, 3), v); chk("R7 random device address", v, dexp);
      rd(cha(ch, 5), v); chk("R8 random done", v, 32'd4);
    end
    chk("R6 bus hold violations", 32'(hold_err), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule